// File: doc/BRIEF.md
# Pipelined Phase Accumulator Without Input Preskew

This block is the phase register of a direct digital synthesiser. On every clock it adds a frequency control word to a running phase, modulo 2^W, with W = 12 by default. The carry does not ripple across the whole word in one cycle. The adder is split into one-bit slices, and each slice holds one sum bit plus one carry register. A carry produced in slice k is consumed by slice k+1 on the next clock, so slice k works on a given accumulation step k cycles after slice 0 does.

The usual triangle of input registers that delays control bit k by k cycles is left out. Each slice adds its own control bit straight from the input port on every clock. On the output side, bit k passes through W-1-k alignment registers, so all output bits describe the same accumulation step. While the word is held, the phase advances by the word on every clock. When the word changes, the staggered pickup by the slices adds a fixed, computable offset, the phase jump, compared with an ideally preskewed accumulator. Downstream processing is expected to compensate for this offset.

Top module: `pacc_top`

## Requirements
- R1: While reset is sampled high, every sum, carry and alignment register is cleared. The phase output reads 0 on the clock after any cycle in which reset was high.
- R2: Number the clock edges since reset released from 1. Let w(e) be the word sampled at edge e, and let C_k(m) be the count of edges 1..m at which bit k of w was 1 (0 for m <= 0). After edge t the output equals the sum over k of 2^k * C_k(t-11+k), modulo 4096. Output bit k therefore reflects words up to edge t-11+k, and the MSB responds one edge after a change.
- R3: Once the same word F has been sampled on 12 consecutive edges, each further edge with that word advances the phase output by exactly F modulo 4096.
- R4: Under the condition of R3, the output minus the ideal accumulator value (the sum of words at edges 1..t-11, modulo 4096) equals J(F) = sum over k of k * F[k] * 2^k, modulo 4096. This difference stays constant as long as the word is held.
- R5: After a change from a steady word A to a steady word B, the steady difference from the ideal accumulator moves by J(B) - J(A) modulo 4096.
- R6: A word of 0 held for 12 consecutive edges freezes the phase output.
- R7: The phase wraps modulo 4096. A steady step that overflows 12 bits yields the low 12 bits of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers update on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| fcw_i | input | W | Frequency control word, sampled by every slice on every edge |
| phase_o | output | W | Aligned phase word |

## Verification
Two things can meet in the same cycle. A new control word enters the low slices while carries produced by the previous word are still travelling through the upper slices, so a single output word can mix contributions from both words. The bench provokes this by changing the word on every clock for a long stretch, and by changing it at a wrap boundary. An edge-exact per-bit count model, driven only by the R2 formula, judges every output word. Across steady stretches, the offset from an ideal accumulator is judged against J(F), and the step between stretches against J(B) - J(A).

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    // State held by one bit slice of the accumulator.
    typedef struct packed {
        logic sum;
        logic carry;
    } slice_state_t;

endpackage

// File: rtl/pacc_slice.sv
module pacc_slice
    import pacc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic word_bit_i,
    input  logic carry_in_i,
    output logic sum_o,
    output logic carry_o
);

    slice_state_t st_d, st_q;
    logic [1:0]   add_w;

    always_comb begin
        add_w = {1'b0, word_bit_i} + {1'b0, carry_in_i} + {1'b0, st_q.sum};
        st_d  = st_q;
        st_d.sum   = add_w[0];
        st_d.carry = add_w[1];
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sum_o   = st_q.sum;
    assign carry_o = st_q.carry;

endmodule

// File: rtl/pacc_align.sv
module pacc_align #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic bit_o
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign bit_o = bit_i;
        end else begin : g_chain
            logic [DEPTH-1:0] sh_d, sh_q;
            logic             rst_seen_q;

            always_comb begin
                sh_d = DEPTH'({sh_q, bit_i});
                if (rst_i) begin
                    sh_d = '0;
                end
            end

            always_ff @(posedge clk_i) begin
                sh_q       <= sh_d;
                rst_seen_q <= rst_i;
            end

            assign bit_o = sh_q[DEPTH-1];

            always_ff @(posedge clk_i) begin
                if (rst_seen_q) begin
                    // R1
                    align_rst_chk: assert (sh_q == '0)
                        else $error("alignment chain not cleared by reset");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] fcw_i,
    output logic [W-1:0] phase_o
);

    localparam int unsigned RUN_W   = $clog2(W + 2);
    localparam int unsigned RUN_MAX = W + 1;

    logic [W-1:0] sum_w;
    logic [W-1:0] carry_w;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_bit
            logic cin_w;
            if (k == 0) begin : g_first
                assign cin_w = 1'b0;
            end else begin : g_rest
                assign cin_w = carry_w[k-1];
            end

            pacc_slice u_slice (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .word_bit_i (fcw_i[k]),
                .carry_in_i (cin_w),
                .sum_o      (sum_w[k]),
                .carry_o    (carry_w[k])
            );

            pacc_align #(.DEPTH(W - 1 - k)) u_align (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .bit_i (sum_w[k]),
                .bit_o (phase_o[k])
            );
        end
    endgenerate

    // ------------------------------------------------------------------
    // Checker state: length of the current run of identical words.
    // ------------------------------------------------------------------
    typedef struct packed {
        logic [W-1:0]     prev;
        logic [RUN_W-1:0] run;
    } mon_t;

    mon_t mon_d, mon_q;
    logic rst_seen_q;

    always_comb begin
        mon_d = mon_q;
        if (fcw_i == mon_q.prev) begin
            if (mon_q.run != RUN_W'(RUN_MAX)) begin
                mon_d.run = mon_q.run + 1'b1;
            end
        end else begin
            mon_d.run = RUN_W'(1);
        end
        mon_d.prev = fcw_i;
        if (rst_i) begin
            mon_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        mon_q      <= mon_d;
        rst_seen_q <= rst_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_seen_q) begin
            // R1
            phase_rst_chk: assert (phase_o == '0)
                else $error("phase not cleared after reset");
            // R1
            carry_rst_chk: assert (carry_w == '0)
                else $error("carry registers not cleared after reset");
        end
    end

    // R3
    steady_rate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mon_q.run >= RUN_W'(W)) |-> (phase_o == W'($past(phase_o) + mon_q.prev)))
        else $error("steady phase step differs from word");

    // R6
    zero_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((mon_q.run >= RUN_W'(W)) && (mon_q.prev == '0)) |-> $stable(phase_o))
        else $error("phase moved under a zero word");

endmodule

// File: tb/test_pacc_top.sv
module test_pacc_top;

    localparam int W     = 12;
    localparam int LAT   = W - 1;
    localparam int MASK  = (1 << W) - 1;
    localparam int MAXE  = 8191;

    logic         clk;
    logic         rst;
    logic [W-1:0] fcw;
    logic [W-1:0] phase;

    int total;
    int bad;
    bit done;

    int ecnt;
    logic [W-1:0] whist [0:MAXE];
    int cnt  [0:MAXE][0:W-1];
    int psum [0:MAXE];
    int last_out;
    bit have_s;
    int last_sF;
    int last_sdiff;

    pacc_top #(.W(W)) i_pacc_top (
        .clk_i   (clk),
        .rst_i   (rst),
        .fcw_i   (fcw),
        .phase_o (phase)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int model(int t);
        int acc = 0;
        for (int k = 0; k < W; k++) begin
            int m = t - LAT + k;
            if (m > 0) acc += cnt[m][k] << k;
        end
        return acc & MASK;
    endfunction

    function automatic int jmp(int f);
        int acc = 0;
        for (int k = 0; k < W; k++) begin
            if (((f >> k) & 1) != 0) acc += k << k;
        end
        return acc & MASK;
    endfunction

    function automatic bit steady(int t);
        if (t < W) return 1'b0;
        for (int i = 1; i < W; i++) begin
            if (whist[t-i] != whist[t]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, ecnt);
        end
    endtask

    task automatic check_out();
        int out;
        int f;
        int diff;
        out = int'(phase);
        // R2: exact per-bit model
        chk(out == model(ecnt), "R2", out, model(ecnt));
        if (steady(ecnt)) begin
            f    = int'(whist[ecnt]);
            diff = (out - psum[ecnt-LAT]) & MASK;
            // R3: steady step
            chk(((out - last_out) & MASK) == f, "R3", (out - last_out) & MASK, f);
            // R4: offset versus ideal accumulator
            chk(diff == jmp(f), "R4", diff, jmp(f));
            // R7: wrap on overflowing step
            if (last_out + f > MASK)
                chk(out == ((last_out + f) & MASK), "R7", out, (last_out + f) & MASK);
            // R6: zero word freezes phase
            if (f == 0)
                chk(out == last_out, "R6", out, last_out);
            // R5: phase jump between steady words
            if (have_s && f != last_sF)
                chk(((diff - last_sdiff) & MASK) == ((jmp(f) - jmp(last_sF)) & MASK),
                    "R5", (diff - last_sdiff) & MASK, (jmp(f) - jmp(last_sF)) & MASK);
            have_s     = 1'b1;
            last_sF    = f;
            last_sdiff = diff;
        end
        last_out = out;
    endtask

    // Starts and ends at a falling edge.
    task automatic drive(input logic [W-1:0] w);
        int e;
        check_out();
        fcw = w;
        e = ecnt + 1;
        whist[e] = w;
        for (int k = 0; k < W; k++) cnt[e][k] = cnt[e-1][k] + int'(w[k]);
        psum[e] = (psum[e-1] + int'(w)) & MASK;
        @(posedge clk);
        ecnt = e;
        @(negedge clk);
    endtask

    task automatic hold(input logic [W-1:0] w, input int n);
        for (int i = 0; i < n; i++) drive(w);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fcw = W'($urandom);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: output cleared under reset
        chk(phase == '0, "R1", int'(phase), 0);
        rst    = 1'b0;
        ecnt   = 0;
        whist[0] = '0;
        psum[0]  = 0;
        for (int k = 0; k < W; k++) cnt[0][k] = 0;
        last_out = 0;
        have_s   = 1'b0;
    endtask

    initial begin
        int seed_r;
        total = 0;
        bad   = 0;
        done  = 1'b0;
        rst   = 1'b1;
        fcw   = '0;
        seed_r = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        hold(12'h001, 30);
        hold(12'h800, 30);
        hold(12'hFFF, 30);
        hold(12'h000, 20);
        hold(12'h555, 20);
        hold(12'hAAA, 20);
        hold(12'hF00, 20);

        // word changes on every edge: carries from old words still in flight
        for (int i = 0; i < 300; i++) drive(W'($urandom));

        for (int i = 0; i < 80; i++) hold(W'($urandom), 12 + int'($urandom % 20));

        // reset in the middle of a run
        do_reset();
        hold(W'($urandom), 30);
        hold(12'h000, 20);
        hold(12'h7FF, 30);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule